// File: doc/BRIEF.md
# Residue Add, Subtract and Compare Unit

This block is a clocked arithmetic unit for signed integers held in residue form over the moduli 31, 15 and 2. Each operand is a 5-bit residue modulo 31, a 4-bit residue modulo 15 and a 1-bit residue modulo 2. Together they cover a dynamic range of 930 values. A positional value X from 0 to 464 stands for the number X itself. A value from 465 to 929 stands for X − 930.

A 2-bit opcode selects one of four actions: add, subtract, compare, or hold. Addition and subtraction run in each residue channel on its own, with no carry passing between channels. The sign, the signed ordering of the operands and the overflow condition cannot be read from the residues directly. For these, the block rebuilds the positional value with a Chinese-remainder sum. All outputs come from registers that update on the rising clock edge.

Top module: `rns_asc_unit`

## Requirements
- R1: Operands and results are canonical residue triples (mod-31 field 0..30, mod-15 field 0..14, mod-2 field 0..1). Positional value X in 0..464 means X, and X in 465..929 means X − 930. Given canonical operands, the result fields stay canonical.
- R2: With opcode 2'b00 the result fields become (a+b) mod 31, (a+b) mod 15 and (a+b) mod 2, each computed in its own channel.
- R3: With opcode 2'b01 the result fields become (a−b) mod 31, (a−b) mod 15 and (a−b) mod 2, each computed in its own channel.
- R4: After an add or subtract, the overflow flag is 1 exactly when the true signed sum or difference lies outside −465..464.
- R5: After an add or subtract, the zero flag is 1 exactly when all three result residues are zero.
- R6: After an add or subtract, the negative flag is 1 exactly when the positional value of the result is 465 or more.
- R7: With opcode 2'b10 the compare code becomes 2'b00 if A equals B, 2'b01 if A is greater than B, and 2'b10 if A is less than B, all in signed terms. The result residues and all three flags keep their values.
- R8: Add and subtract leave the compare code unchanged. Opcode 2'b11 leaves every output unchanged. The compare code never takes the value 2'b11.
- R9: Every output reflects the inputs sampled at the rising edge just before it, a latency of one cycle.
- R10: When rst is high at a rising edge, every output and flag becomes zero at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 2 | 00 add, 01 subtract, 10 compare, 11 hold |
| a_m31 | input | 5 | Operand A residue mod 31 |
| a_m15 | input | 4 | Operand A residue mod 15 |
| a_m2 | input | 1 | Operand A residue mod 2 |
| b_m31 | input | 5 | Operand B residue mod 31 |
| b_m15 | input | 4 | Operand B residue mod 15 |
| b_m2 | input | 1 | Operand B residue mod 2 |
| sum_m31 | output | 5 | Result residue mod 31 |
| sum_m15 | output | 4 | Result residue mod 15 |
| sum_m2 | output | 1 | Result residue mod 2 |
| cmp_code | output | 2 | Signed comparison code |
| zero_flag | output | 1 | Result is zero |
| neg_flag | output | 1 | Result is negative |
| ovf_flag | output | 1 | Signed overflow on add or subtract |

## Verification
Two kinds of cases are hard to reach with random operands.

The first is the set of overflow boundaries. Random operands seldom land exactly on the edges of the range, such as 464 + 1, −465 + (−1), 0 − (−465) or −465 − (−465). At these points the wrapped residues fall just across the sign boundary. The stimulus drives these operand pairs directly, alongside a uniform random sweep.

The second is signed comparison across opposite signs. For example, −1 against 1 has a larger positional value on the smaller number, so an unsigned comparison would give the wrong answer. Directed pairs at both range ends reach these cases.

// File: rtl/rns_asc_unit.sv
module rns_asc_unit (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] op,
  input  logic [4:0] a_m31,
  input  logic [3:0] a_m15,
  input  logic       a_m2,
  input  logic [4:0] b_m31,
  input  logic [3:0] b_m15,
  input  logic       b_m2,
  output logic [4:0] sum_m31,
  output logic [3:0] sum_m15,
  output logic       sum_m2,
  output logic [1:0] cmp_code,
  output logic       zero_flag,
  output logic       neg_flag,
  output logic       ovf_flag
);
  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_SUB = 2'b01;
  localparam logic [1:0] OP_CMP = 2'b10;
  localparam logic [9:0] HALF   = 10'd465;

  // CRT weights for 31,15,2 with M = 930
  function automatic logic [9:0] to_pos(input logic [4:0] r31, input logic [3:0] r15, input logic r2);
    logic [15:0] s;
    s = 16'(r31) * 16'd900 + 16'(r15) * 16'd496 + (r2 ? 16'd465 : 16'd0);
    return 10'(s % 16'd930);
  endfunction

  logic [5:0] t31;
  logic [4:0] t15;
  logic [4:0] n31;
  logic [3:0] n15;
  logic       n2;
  logic       is_sub;

  assign is_sub = (op == OP_SUB);

  always_comb begin
    t31 = is_sub ? 6'(a_m31) + 6'd31 - 6'(b_m31) : 6'(a_m31) + 6'(b_m31);
    t15 = is_sub ? 5'(a_m15) + 5'd15 - 5'(b_m15) : 5'(a_m15) + 5'(b_m15);
    n31 = (t31 >= 6'd31) ? 5'(t31 - 6'd31) : t31[4:0];
    n15 = (t15 >= 5'd15) ? 4'(t15 - 5'd15) : t15[3:0];
  end
  assign n2 = a_m2 ^ b_m2;

  logic [9:0] xa, xb, xn;
  logic       sa, sb, sn, ovf_n, zero_n;
  logic [1:0] cmp_n;

  assign xa = to_pos(a_m31, a_m15, a_m2);
  assign xb = to_pos(b_m31, b_m15, b_m2);
  assign xn = to_pos(n31, n15, n2);
  assign sa = (xa >= HALF);
  assign sb = (xb >= HALF);
  assign sn = (xn >= HALF);
  assign zero_n = (n31 == 5'd0) && (n15 == 4'd0) && !n2;
  assign ovf_n  = is_sub ? (sa != sb) && (sn != sa) : (sa == sb) && (sn != sa);

  always_comb begin
    if (xa == xb)     cmp_n = 2'b00;
    else if (sa != sb) cmp_n = sb ? 2'b01 : 2'b10;
    else              cmp_n = (xa > xb) ? 2'b01 : 2'b10;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_m31   <= '0;
      sum_m15   <= '0;
      sum_m2    <= 1'b0;
      cmp_code  <= 2'b00;
      zero_flag <= 1'b0;
      neg_flag  <= 1'b0;
      ovf_flag  <= 1'b0;
    end else if (op == OP_ADD || op == OP_SUB) begin
      sum_m31   <= n31;
      sum_m15   <= n15;
      sum_m2    <= n2;
      zero_flag <= zero_n;
      neg_flag  <= sn;
      ovf_flag  <= ovf_n;
    end else if (op == OP_CMP) begin
      cmp_code  <= cmp_n;
    end
  end

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (sum_m31 == 5'd0 && sum_m15 == 4'd0 && !sum_m2 && cmp_code == 2'b00 &&
             !zero_flag && !neg_flag && !ovf_flag));

  assert_canonical_R1: assert property (@(posedge clk) disable iff (rst)
    (op[1] == 1'b0 && a_m31 < 5'd31 && b_m31 < 5'd31 && a_m15 < 4'd15 && b_m15 < 4'd15)
      |=> (sum_m31 < 5'd31 && sum_m15 < 4'd15));

  assert_zero_not_neg_R5: assert property (@(posedge clk) disable iff (rst)
    zero_flag |-> (!neg_flag && sum_m31 == 5'd0 && sum_m15 == 4'd0 && !sum_m2));

  assert_cmp_keeps_result_R7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP) |=> ($stable({sum_m31, sum_m15, sum_m2}) && $stable({zero_flag, neg_flag, ovf_flag})));

  assert_arith_keeps_cmp_R8: assert property (@(posedge clk) disable iff (rst)
    (op[1] == 1'b0) |=> $stable(cmp_code));

  assert_hold_all_R8: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b11) |=> ($stable({sum_m31, sum_m15, sum_m2, cmp_code}) && $stable({zero_flag, neg_flag, ovf_flag})));

  assert_cmp_code_R8: assert property (@(posedge clk) disable iff (rst)
    cmp_code != 2'b11);
endmodule

// File: tb/sim_rns_asc_unit.sv
module sim_rns_asc_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op = 2'b11;
  logic [4:0] a_m31 = '0, b_m31 = '0;
  logic [3:0] a_m15 = '0, b_m15 = '0;
  logic       a_m2 = 1'b0, b_m2 = 1'b0;
  logic [4:0] sum_m31;
  logic [3:0] sum_m15;
  logic       sum_m2;
  logic [1:0] cmp_code;
  logic       zero_flag, neg_flag, ovf_flag;

  int checks = 0;
  int errors = 0;
  int e31 = 0, e15 = 0, e2 = 0, ecmp = 0, ez = 0, en = 0, eo = 0;

  always #5 clk = ~clk;

  rns_asc_unit u0 (
    .clk(clk), .rst(rst), .op(op),
    .a_m31(a_m31), .a_m15(a_m15), .a_m2(a_m2),
    .b_m31(b_m31), .b_m15(b_m15), .b_m2(b_m2),
    .sum_m31(sum_m31), .sum_m15(sum_m15), .sum_m2(sum_m2),
    .cmp_code(cmp_code), .zero_flag(zero_flag), .neg_flag(neg_flag), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R1: signed value to positional value, 0..929
  function automatic int pos(input int v);
    return (v < 0) ? v + 930 : v;
  endfunction

  task automatic compare_all(input string rt, input string ft, input string ct);
    chk({rt, " res31"}, int'(sum_m31), e31);
    chk({rt, " res15"}, int'(sum_m15), e15);
    chk({rt, " res2"},  int'(sum_m2),  e2);
    chk({ft, " ovf"},   int'(ovf_flag), eo);
    chk({ft == "R4" ? "R5" : ft, " zero"}, int'(zero_flag), ez);
    chk({ft == "R4" ? "R6" : ft, " neg"},  int'(neg_flag),  en);
    chk({ct, " cmp"},   int'(cmp_code), ecmp);
  endtask

  // one clock: drive, edge, update model, compare (R9 one-cycle latency)
  task automatic step(input int o, input int a, input int b);
    int pa, pb, t, w;
    pa = pos(a); pb = pos(b);
    op = 2'(o);
    a_m31 = 5'(pa % 31); a_m15 = 4'(pa % 15); a_m2 = 1'(pa % 2);
    b_m31 = 5'(pb % 31); b_m15 = 4'(pb % 15); b_m2 = 1'(pb % 2);
    @(posedge clk);
    #2;
    if (o < 2) begin
      t = (o == 0) ? a + b : a - b;
      eo = (t > 464 || t < -465) ? 1 : 0;
      w = ((t % 930) + 930) % 930;
      e31 = w % 31; e15 = w % 15; e2 = w % 2;
      en = (w >= 465) ? 1 : 0;
      ez = (w == 0) ? 1 : 0;
    end else if (o == 2) begin
      ecmp = (a == b) ? 0 : (a > b) ? 1 : 2;
    end
    case (o)
      0: compare_all("R2/R9", "R4", "R8");
      1: compare_all("R3/R9", "R4", "R8");
      2: compare_all("R7", "R7", "R7/R9");
      default: compare_all("R8", "R8", "R8");
    endcase
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk); #2;
    @(posedge clk); #2;
    compare_all("R10", "R10", "R10");
    rst = 1'b0;
    step(0, 3, 4);
    step(0, 464, 1);        // R4 positive overflow
    step(0, -465, -1);      // R4 negative overflow
    step(0, -465, -465);    // R4 wrap to zero
    step(1, 0, -465);       // R4 subtract overflow
    step(1, -465, 1);
    step(1, -465, -465);    // R5 zero result
    step(0, 0, 0);
    step(1, 100, 200);      // R6 negative result
    step(0, 464, -465);
    step(2, 7, 7);          // R7 equal
    step(2, -1, 1);         // R7 sign split
    step(2, 1, -1);
    step(2, 464, -465);
    step(2, -465, 464);
    step(2, -5, -3);
    step(3, 50, 60);        // R8 hold
    step(0, 12, 13);
    step(3, 1, 1);
    for (int i = 0; i < 400; i++) begin
      step(int'($urandom_range(3)), int'($urandom_range(929)) - 465, int'($urandom_range(929)) - 465);
    end
    op = 2'b00; a_m31 = 5'd9; b_m31 = 5'd3;
    rst = 1'b1;
    @(posedge clk); #2;
    e31 = 0; e15 = 0; e2 = 0; ecmp = 0; ez = 0; en = 0; eo = 0;
    compare_all("R10", "R10", "R10");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule